// File: doc/BRIEF.md
# Bootloader command and page buffer engine

This block sits behind a bus slave byte interface and turns the bytes a host master writes into bootloader actions. A byte's meaning depends on its position in the write transfer, so each written byte arrives with its index. The engine answers every written byte with an acknowledge decision and supplies a byte for each read transfer. Through this interface the host can query a version string and a chip description, read flash or EEPROM, fill a page buffer and commit it to flash, and write EEPROM bytes.

A boot countdown, driven by an external 25 ms tick, hands control to the application when no host talks to the bootloader in time. A valid first command byte cancels the countdown. A one-cycle `boot_app` pulse tells the surrounding system to start the application. A flash page commit is a request and done handshake. While a commit is pending, `ready` stays low so that the bus slave keeps stretching the clock.

Top module: `boot_cmd_engine`

## Requirements
- R1: At write index 0, a data value of 0x00 (wait), 0x01 (switch/version) or 0x02 (memory) is acknowledged, selects that command and stops the boot countdown. Any other value is not acknowledged and raises `boot_app` for one cycle, one clock after the byte.
- R2: After the switch command, the byte at index 1 is never acknowledged. If its value is 0x80, `boot_app` pulses one clock later. Any other value gives no pulse.
- R3: After the memory command, index 1 selects chip info (0x00), flash (0x01) or EEPROM (0x02) with an acknowledge. Any other value is not acknowledged.
- R4: The bytes at indices 2 and 3 are acknowledged and shift into the 16-bit address, high byte first. The address appears on `mem_addr`.
- R5: In flash or EEPROM mode, a byte at index 4 or above belongs to buffer position index−4. It is acknowledged only while that position is below PAGE−2. In flash mode the byte is stored in the page buffer, which can be read back through `pg_pos`/`pg_byte`.
- R6: In flash mode, filling position PAGE−1 starts a page commit: `pg_req` rises one clock later and `pg_addr` holds the address. In EEPROM mode, every data byte gives a one-cycle `eep_we` with `eep_addr` equal to the current address and `eep_wdata` equal to the byte, and the address then increments.
- R7: After the version command, a read at index k returns byte k mod 16 of the VERSION string, first character first. After chip info, a read at index k returns byte k mod 8 of this sequence: 3 signature bytes (most significant first), the page size, the flash size high then low byte (equal to BOOT_START), and the EEPROM size high then low byte.
- R8: In flash or EEPROM mode, a read returns `flash_rdata` or `eep_rdata` for the current `mem_addr`, and the address then increments by one. In any other command state, a read returns 0xFF.
- R9: After reset, the countdown starts at TIMEOUT_TICKS. Ticks decrement it down to 1, and the next tick pulses `boot_app`, so the pulse follows the TIMEOUT_TICKS-th tick. Once the countdown is cancelled, ticks have no effect.
- R10: A page whose address is at or above BOOT_START is never committed: `pg_req` stays low.
- R11: Once a commit has started, `pg_req` stays high and `ready` stays low until a cycle with `pg_done`. After that cycle, `ready` is high and `pg_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | 25 ms time base pulse |
| wr_valid | input | 1 | A written byte is present |
| wr_idx | input | 8 | Position of the byte in the write transfer |
| wr_data | input | 8 | Written byte |
| wr_ack | output | 1 | Acknowledge decision for the written byte (combinational) |
| rd_req | input | 1 | A read byte is taken this cycle |
| rd_idx | input | 8 | Position of the byte in the read transfer |
| rd_data | output | 8 | Byte for the read transfer (combinational) |
| mem_addr | output | 16 | Current address for memory reads |
| flash_rdata | input | 8 | Flash byte at `mem_addr` |
| eep_rdata | input | 8 | EEPROM byte at `mem_addr` |
| pg_req | output | 1 | Page commit request |
| pg_addr | output | 16 | Start address of the page to commit |
| pg_done | input | 1 | Page commit finished |
| pg_pos | input | AW | Buffer position to read out |
| pg_byte | output | 8 | Buffer byte at `pg_pos` |
| eep_we | output | 1 | EEPROM byte write strobe |
| eep_addr | output | 16 | EEPROM write address |
| eep_wdata | output | 8 | EEPROM write data |
| ready | output | 1 | Low while a page commit is pending |
| boot_app | output | 1 | One-cycle application boot request |

## Verification
The first byte is driven with each of the three valid commands and with random invalid values, which separates countdown cancellation from an immediate boot. Page fills use random data at random page-aligned addresses below the protected region, plus one page inside it. These tell apart the acknowledge timing two positions early, the commit trigger on the final position, and commit suppression. Reads from random start addresses, in flash and EEPROM modes and past the version and chip-info lengths, show the post-increment and the wrap of each table. A run of ticks counted against the timeout, with and without a cancelling command, pins the countdown to its exact tick.

// File: rtl/boot_cmd_engine.sv
module boot_cmd_engine #(
  parameter int PAGE = 64,
  parameter logic [15:0] BOOT_START = 16'h1C00,
  parameter int TIMEOUT_TICKS = 40,
  parameter logic [23:0] SIGNATURE = 24'h1E930B,
  parameter logic [15:0] EEP_SIZE = 16'h0200,
  parameter logic [127:0] VERSION = "CMDENGINE v1.00 ",
  localparam int AW = $clog2(PAGE),
  localparam int TW = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_valid,
  input  logic [7:0]    wr_idx,
  input  logic [7:0]    wr_data,
  output logic          wr_ack,
  input  logic          rd_req,
  input  logic [7:0]    rd_idx,
  output logic [7:0]    rd_data,
  output logic [15:0]   mem_addr,
  input  logic [7:0]    flash_rdata,
  input  logic [7:0]    eep_rdata,
  output logic          pg_req,
  output logic [15:0]   pg_addr,
  input  logic          pg_done,
  input  logic [AW-1:0] pg_pos,
  output logic [7:0]    pg_byte,
  output logic          eep_we,
  output logic [15:0]   eep_addr,
  output logic [7:0]    eep_wdata,
  output logic          ready,
  output logic          boot_app
);
  typedef enum logic [2:0] {C_NONE, C_WAIT, C_SWITCH, C_MEM, C_CHIP, C_FLASH, C_EEP} cmd_t;

  localparam logic [63:0] CHIP = {SIGNATURE, 8'(PAGE), BOOT_START, EEP_SIZE};

  cmd_t          cmd;
  logic [15:0]   addr;
  logic [TW-1:0] tcnt;
  logic          busy;
  logic [7:0]    pbuf [PAGE];
  logic [7:0]    pos;
  logic          datamode;
  logic [127:0]  vsh;
  logic [63:0]   csh;

  assign pos      = wr_idx - 8'd4;
  assign datamode = (cmd == C_FLASH) || (cmd == C_EEP);
  assign mem_addr = addr;
  assign pg_req   = busy;
  assign ready    = !busy;
  assign pg_byte  = pbuf[pg_pos];
  assign vsh      = VERSION >> {~rd_idx[3:0], 3'b000};
  assign csh      = CHIP >> {~rd_idx[2:0], 3'b000};

  always_comb begin
    case (wr_idx)
      8'd0:       wr_ack = wr_data <= 8'd2;
      8'd1:       wr_ack = (cmd == C_MEM) && (wr_data <= 8'd2);
      8'd2, 8'd3: wr_ack = 1'b1;
      default:    wr_ack = datamode && (int'(pos) < PAGE - 2);
    endcase
  end

  always_comb begin
    case (cmd)
      C_SWITCH: rd_data = vsh[7:0];
      C_CHIP:   rd_data = csh[7:0];
      C_FLASH:  rd_data = flash_rdata;
      C_EEP:    rd_data = eep_rdata;
      default:  rd_data = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_valid && cmd == C_FLASH && wr_idx >= 8'd4 && int'(pos) < PAGE)
      pbuf[pos[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd       <= C_NONE;
      addr      <= '0;
      tcnt      <= TW'(TIMEOUT_TICKS);
      busy      <= 1'b0;
      pg_addr   <= '0;
      eep_we    <= 1'b0;
      eep_addr  <= '0;
      eep_wdata <= '0;
      boot_app  <= 1'b0;
    end else begin
      boot_app <= 1'b0;
      eep_we   <= 1'b0;
      if (tick) begin
        if (tcnt > TW'(1)) tcnt <= tcnt - TW'(1);
        else if (tcnt == TW'(1)) begin
          boot_app <= 1'b1;
          tcnt     <= '0;
        end
      end
      if (busy && pg_done) busy <= 1'b0;
      if (rd_req && datamode) addr <= addr + 16'd1;
      if (wr_valid) begin
        case (wr_idx)
          8'd0:
            if (wr_data <= 8'd2) begin
              tcnt <= '0;
              cmd  <= (wr_data == 8'd0) ? C_WAIT : (wr_data == 8'd1) ? C_SWITCH : C_MEM;
            end else begin
              boot_app <= 1'b1;
              cmd      <= C_NONE;
            end
          8'd1: begin
            if (cmd == C_SWITCH && wr_data == 8'h80) boot_app <= 1'b1;
            if (cmd == C_MEM)
              case (wr_data)
                8'd0: cmd <= C_CHIP;
                8'd1: cmd <= C_FLASH;
                8'd2: cmd <= C_EEP;
                default: ;
              endcase
          end
          8'd2, 8'd3: addr <= {addr[7:0], wr_data};
          default:
            if (cmd == C_FLASH) begin
              if (int'(pos) == PAGE - 1 && addr < BOOT_START) begin
                busy    <= 1'b1;
                pg_addr <= addr;
              end
            end else if (cmd == C_EEP) begin
              eep_we    <= 1'b1;
              eep_addr  <= addr;
              eep_wdata <= wr_data;
              addr      <= addr + 16'd1;
            end
        endcase
      end
    end
  end
endmodule

// File: rtl/boot_cmd_engine_chk.sv
module boot_cmd_engine_chk #(
  parameter int PAGE = 64,
  parameter logic [15:0] BOOT_START = 16'h1C00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [7:0]  wr_idx,
  input logic [7:0]  wr_data,
  input logic        wr_ack,
  input logic        pg_req,
  input logic        pg_done,
  input logic [15:0] pg_addr,
  input logic        eep_we,
  input logic        boot_app
);
  p_bad_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_idx == 8'd0 && wr_data > 8'd2 |-> !wr_ack);

  p_bad_first_boot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_idx == 8'd0 && wr_data > 8'd2 |=> boot_app);

  p_nak_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_idx >= 8'(PAGE + 2) |-> !wr_ack);

  p_commit_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_req) |-> $past(wr_valid) && $past(wr_idx) == 8'(PAGE + 3));

  p_eep_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eep_we |-> $past(wr_valid));

  p_protect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_req) |-> pg_addr < BOOT_START);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req && !pg_done |=> pg_req);
endmodule

bind boot_cmd_engine boot_cmd_engine_chk #(.PAGE(PAGE), .BOOT_START(BOOT_START)) u_chk (.*);

// File: tb/sim_boot_cmd_engine.sv
module sim_boot_cmd_engine;
  localparam int PAGE = 64;
  localparam logic [15:0] BOOT_START = 16'h1C00;
  localparam int TO = 40;
  localparam logic [127:0] VER = "CMDENGINE v1.00 ";
  localparam logic [63:0] CHIPV = {24'h1E930B, 8'd64, 16'h1C00, 16'h0200};

  logic clk = 0, rst_n = 0, tick = 0, wr_valid = 0, rd_req = 0, pg_done = 0;
  logic [7:0] wr_idx = 0, wr_data = 0, rd_idx = 0;
  logic [5:0] pg_pos = 0;
  logic wr_ack, pg_req, eep_we, ready, boot_app;
  logic [7:0] rd_data, flash_rdata, eep_rdata, pg_byte, eep_wdata;
  logic [15:0] mem_addr, pg_addr, eep_addr;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] page [PAGE];

  always #5 clk = ~clk;

  function automatic logic [7:0] fexp(logic [15:0] a); return a[7:0] ^ a[15:8] ^ 8'hA5; endfunction
  function automatic logic [7:0] eexp(logic [15:0] a); return a[7:0] + a[15:8] + 8'd3; endfunction
  function automatic logic [7:0] vbyte(int k); return VER[127 - 8*(k % 16) -: 8]; endfunction
  function automatic logic [7:0] cbyte(int k); return CHIPV[63 - 8*(k % 8) -: 8]; endfunction

  assign flash_rdata = fexp(mem_addr);
  assign eep_rdata   = eexp(mem_addr);

  boot_cmd_engine u0 (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; #2; rst_n = 1;
  endtask

  task automatic wr(string r, int idx, logic [7:0] d, logic exp_ack);
    @(negedge clk);
    wr_valid = 1; wr_idx = 8'(idx); wr_data = d;
    #1 chk(r, wr_ack, exp_ack);
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic rd(string r, int idx, logic [7:0] exp);
    @(negedge clk);
    rd_req = 1; rd_idx = 8'(idx);
    #1 chk(r, rd_data, exp);
    @(posedge clk); #1 rd_req = 0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1; @(posedge clk); #1 tick = 0;
  endtask

  task automatic set_mem(logic [7:0] sel, logic [15:0] a);
    wr("R1", 0, 8'h02, 1);
    wr("R3", 1, sel, 1);
    wr("R4", 2, a[15:8], 1);
    wr("R4", 3, a[7:0], 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd11));
    do_reset();
    #1;
    chk("R11 reset ready", ready, 1);
    chk("R11 reset pg_req", pg_req, 0);
    chk("R9 reset boot", boot_app, 0);
    chk("R6 reset eep_we", eep_we, 0);
    chk("R8 reset read", rd_data, 8'hFF);

    // R9 countdown
    for (int i = 1; i < TO; i++) begin
      do_tick();
      chk("R9 early", boot_app, 0);
    end
    do_tick();
    chk("R9 expire", boot_app, 1);
    @(posedge clk); #1 chk("R9 pulse width", boot_app, 0);

    // R9 cancel by wait command, R8 read without valid command
    do_reset();
    wr("R1 wait", 0, 8'h00, 1);
    for (int i = 0; i < TO + 10; i++) begin
      do_tick();
      chk("R9 cancelled", boot_app, 0);
    end
    rd("R8 no cmd", 0, 8'hFF);

    // R1 invalid first bytes
    for (int i = 0; i < 4; i++) begin
      logic [7:0] v = 8'(3 + ($urandom % 253));
      wr("R1 invalid", 0, v, 0);
      chk("R1 boot", boot_app, 1);
    end

    // R2 switch
    wr("R1 switch", 0, 8'h01, 1);
    wr("R2 other", 1, 8'h55, 0);
    chk("R2 no boot", boot_app, 0);
    for (int k = 0; k < 20; k++) rd("R7 version", k, vbyte(k));
    wr("R1 switch", 0, 8'h01, 1);
    wr("R2 app", 1, 8'h80, 0);
    chk("R2 boot", boot_app, 1);

    // R3 bad select
    wr("R1 mem", 0, 8'h02, 1);
    wr("R3 bad sel", 1, 8'h03, 0);
    rd("R8 bad sel read", 0, 8'hFF);

    // R7 chip info
    set_mem(8'h00, 16'h0000);
    for (int k = 0; k < 10; k++) rd("R7 chip", k, cbyte(k));

    // R4 R8 flash read
    for (int t = 0; t < 3; t++) begin
      logic [15:0] a = 16'($urandom);
      set_mem(8'h01, a);
      @(negedge clk); chk("R4 addr", mem_addr, a);
      for (int k = 0; k < 5; k++) rd("R8 flash", k, fexp(a + 16'(k)));
    end

    // R5 R6 R11 page commit
    for (int t = 0; t < 2; t++) begin
      logic [15:0] a = 16'(($urandom % (BOOT_START / PAGE)) * PAGE);
      set_mem(8'h01, a);
      for (int i = 0; i < PAGE; i++) begin
        page[i] = 8'($urandom);
        wr("R5 ack", i + 4, page[i], (i < PAGE - 2));
        if (i == PAGE - 2) chk("R6 no early commit", pg_req, 0);
      end
      chk("R6 commit", pg_req, 1);
      chk("R11 not ready", ready, 0);
      chk("R6 pg_addr", pg_addr, a);
      for (int i = 0; i < PAGE; i += 7) begin
        @(negedge clk); pg_pos = 6'(i);
        #1 chk("R5 buffer", pg_byte, page[i]);
      end
      repeat (5) @(posedge clk);
      #1 chk("R11 hold", pg_req, 1);
      @(negedge clk); pg_done = 1; @(posedge clk); #1 pg_done = 0;
      chk("R11 ready", ready, 1);
      chk("R11 released", pg_req, 0);
    end

    // R10 protected page
    set_mem(8'h01, BOOT_START);
    for (int i = 0; i < PAGE; i++) wr("R5 ack", i + 4, 8'($urandom), (i < PAGE - 2));
    @(posedge clk); #1 chk("R10 no commit", pg_req, 0);

    // R6 EEPROM writes
    begin
      logic [15:0] a = 16'($urandom % 16'h01F0);
      set_mem(8'h02, a);
      for (int i = 0; i < 3; i++) begin
        logic [7:0] d = 8'($urandom);
        wr("R5 eep ack", i + 4, d, 1);
        chk("R6 eep_we", eep_we, 1);
        chk("R6 eep_addr", eep_addr, a + 16'(i));
        chk("R6 eep_wdata", eep_wdata, d);
      end
      @(posedge clk); #1 chk("R6 eep_we pulse", eep_we, 0);
      chk("R6 eep post inc", mem_addr, a + 16'd3);
      set_mem(8'h02, a);
      for (int k = 0; k < 4; k++) rd("R8 eeprom", k, eexp(a + 16'(k)));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule